// File: doc/BRIEF.md
# Prioritised Interrupt Acceptance Unit

This block sits between the interrupt message fabric and a processor core. It takes one interrupt request per cycle. Each request carries an 8-bit vector, a 3-bit delivery-mode code and a level/edge flag. Ordinary requests (fixed and lowest-priority) are kept as bits in a 256-entry pending bitmap. A companion bitmap records the trigger kind of each pending bit. A third bitmap records which vectors the core is currently servicing. System-management, non-maskable, init, startup and external requests bypass the bitmaps. Each of these is held in its own single-bit pending flag.

The unit combines the pending state with the task-priority value, which arrives as an input. From these it raises `irq_deliverable`. The core acknowledges by pulsing `ack`. In the following cycle the unit presents the winner on the grant outputs and retires it from the pending state. A pulse on `eoi` ends service of the highest in-service vector.

Presentation is a two-state machine:
- `ST_IDLE` moves to `ST_PRESENT` on *take*, which is `ack` while deliverable.
- `ST_PRESENT` stays in `ST_PRESENT` on a back-to-back *take*.
- `ST_PRESENT` returns to `ST_IDLE` when there is no *take*.

`grant_valid` is high exactly in `ST_PRESENT`.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, `irq_deliverable` and `grant_valid` are low, and every bitmap and pending flag is empty.
- R2: A request with mode 000 (fixed) or 001 (lowest-priority) sets its vector's pending bit only when that bit is clear. On acceptance, the trigger bit for that vector becomes `req_level`. A request for an already pending vector changes nothing. The trigger bit appears as `grant_level` when that vector is granted.
- R3: Mode 010 (system-management), 100 (non-maskable), 101 (init), 110 (startup) and 111 (external) each set their own pending flag. A request whose flag is already set is dropped.
- R4: Startup and external requests store their vector when they are accepted, and a dropped duplicate does not overwrite it. The stored vector is shown on `grant_vector` when that kind is granted. The other special kinds show vector 0. All special kinds show `grant_level` 0.
- R5: A request with the reserved mode 011 changes no state.
- R6: `irq_deliverable` is high whenever any special pending flag is set.
- R7: With no special flag set, `irq_deliverable` is high only when all of the following hold:
  - the pending bitmap is non-empty;
  - its highest vector is above the highest in-service vector (an empty in-service bitmap counts as lower than any vector);
  - bits 7:4 of that vector exceed `task_prio[7:4]`.
- R8: On a take, the winner is the first pending of system-management (kind 0), non-maskable (1), init (2), startup (3), external (4), then regular (5), as coded on `grant_kind`. The winner's flag is cleared.
- R9: `grant_valid` rises in the cycle after a take, and only then. Granting a regular vector clears its pending bit and sets its in-service bit.
- R10: `eoi` clears the highest set in-service bit. It has no effect when the in-service bitmap is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vector | input | 8 | Request vector |
| req_mode | input | 3 | Delivery-mode code |
| req_level | input | 1 | 1 = level request, 0 = edge request |
| task_prio | input | 8 | Task-priority value; bits 7:4 form the class threshold |
| ack | input | 1 | Core acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_deliverable | output | 1 | An interrupt may be taken |
| grant_valid | output | 1 | Grant payload valid |
| grant_kind | output | 3 | Kind of the granted interrupt (0..5) |
| grant_vector | output | 8 | Granted vector |
| grant_level | output | 1 | Trigger bit of a granted regular vector |

## Verification
The assertions assume the following about the inputs:
- `ack` is sampled on the same edge as the `irq_deliverable` it answers.
- `task_prio` is stable between that edge and the grant.
- A grant that follows a take is a consequence of that take alone.

Under these assumptions, a regular grant must beat the class of the `task_prio` value seen at the take. The stimulus drives every input once per cycle, away from the clock edge, and holds it for the full cycle. Requests mix all eight mode codes, including the reserved one. `ack` and `eoi` are raised both when nothing is deliverable and when something is, so both paths of each property are exercised.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;

    localparam int N_SPECIAL = 5;

    typedef enum logic [2:0] {
        DM_FIXED    = 3'b000,
        DM_LOWEST   = 3'b001,
        DM_SMI      = 3'b010,
        DM_RSVD     = 3'b011,
        DM_NMI      = 3'b100,
        DM_INIT     = 3'b101,
        DM_STARTUP  = 3'b110,
        DM_EXTERNAL = 3'b111
    } dmode_t;

    // Grant kinds; the first five double as indices of the special flags.
    typedef enum logic [2:0] {
        GK_SMI      = 3'd0,
        GK_NMI      = 3'd1,
        GK_INIT     = 3'd2,
        GK_STARTUP  = 3'd3,
        GK_EXTERNAL = 3'd4,
        GK_REGULAR  = 3'd5
    } gkind_t;

    function automatic dmode_t special_code(input int idx);
        case (idx)
            0:       return DM_SMI;
            1:       return DM_NMI;
            2:       return DM_INIT;
            3:       return DM_STARTUP;
            default: return DM_EXTERNAL;
        endcase
    endfunction

endpackage

// File: rtl/irq_msb_find.sv
`timescale 1ns/1ps
// Single-cycle highest-set-bit encoder.
module irq_msb_find #(
    parameter int WIDTH = 256,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             found_o,
    output logic [IDX_W-1:0] index_o
);

    always_comb begin
        found_o = |bits_i;
        index_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits_i[i]) begin
                index_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vec_bank.sv
`timescale 1ns/1ps
// Pending, trigger-kind and in-service bitmaps for regular vectors.
module irq_vec_bank #(
    parameter int VEC_W = 8,
    parameter int N_VEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             ack_en,
    input  logic             eoi_en,
    output logic             irr_found,
    output logic [VEC_W-1:0] irr_top,
    output logic             isr_found,
    output logic [VEC_W-1:0] isr_top,
    output logic             top_level
);

    logic [N_VEC-1:0] irr_q, tmr_q, isr_q;
    logic [N_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr;

    irq_msb_find #(.WIDTH(N_VEC), .IDX_W(VEC_W)) u_irr_find (
        .bits_i  (irr_q),
        .found_o (irr_found),
        .index_o (irr_top)
    );

    irq_msb_find #(.WIDTH(N_VEC), .IDX_W(VEC_W)) u_isr_find (
        .bits_i  (isr_q),
        .found_o (isr_found),
        .index_o (isr_top)
    );

    always_comb begin
        irr_set = '0;
        irr_clr = '0;
        isr_set = '0;
        isr_clr = '0;
        if (set_en && !irr_q[set_vec]) begin
            irr_set[set_vec] = 1'b1;
        end
        if (ack_en) begin
            irr_clr[irr_top] = 1'b1;
            isr_set[irr_top] = 1'b1;
        end
        if (eoi_en && isr_found) begin
            isr_clr[isr_top] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            tmr_q <= '0;
            isr_q <= '0;
        end else begin
            irr_q <= (irr_q & ~irr_clr) | irr_set;
            tmr_q <= (tmr_q & ~irr_set) | (irr_set & {N_VEC{set_level}});
            isr_q <= (isr_q & ~isr_clr) | isr_set;
        end
    end

    assign top_level = tmr_q[irr_top];

endmodule

// File: rtl/irq_special_flags.sv
`timescale 1ns/1ps
// Single-bit pending flags for the delivery modes that bypass the bitmaps.
module irq_special_flags
    import irq_accept_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_mode,
    input  logic [VEC_W-1:0]     req_vector,
    input  logic [N_SPECIAL-1:0] clr_mask,
    output logic [N_SPECIAL-1:0] pending_o,
    output logic [VEC_W-1:0]     startup_vec_o,
    output logic [VEC_W-1:0]     ext_vec_o
);

    logic [N_SPECIAL-1:0] pend_q, pend_d, accept_w;

    for (genvar g = 0; g < N_SPECIAL; g++) begin : g_flag
        assign accept_w[g] = req_valid && (req_mode == special_code(g)) && !pend_q[g];
        assign pend_d[g]   = (pend_q[g] && !clr_mask[g]) || accept_w[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q        <= '0;
            startup_vec_o <= '0;
            ext_vec_o     <= '0;
        end else begin
            pend_q <= pend_d;
            if (accept_w[GK_STARTUP]) begin
                startup_vec_o <= req_vector;
            end
            if (accept_w[GK_EXTERNAL]) begin
                ext_vec_o <= req_vector;
            end
        end
    end

    assign pending_o = pend_q;

endmodule

// File: rtl/irq_accept_unit.sv
`timescale 1ns/1ps
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [2:0]       req_mode,
    input  logic             req_level,
    input  logic [VEC_W-1:0] task_prio,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_deliverable,
    output logic             grant_valid,
    output logic [2:0]       grant_kind,
    output logic [VEC_W-1:0] grant_vector,
    output logic             grant_level
);

    localparam int CLS_LO = VEC_W - 4;

    typedef enum logic {
        ST_IDLE,
        ST_PRESENT
    } pst_t;

    pst_t                 state_q, state_d;
    logic                 reg_req, reg_ok, take, ack_reg;
    logic                 irr_found, isr_found, top_level;
    logic [VEC_W-1:0]     irr_top, isr_top, startup_vec, ext_vec;
    logic [N_SPECIAL-1:0] spec_pending, clr_mask;
    gkind_t               win_kind;
    logic [VEC_W-1:0]     win_vector;
    logic                 win_level;

    assign reg_req = req_valid &&
                     (req_mode == DM_FIXED || req_mode == DM_LOWEST);

    irq_vec_bank #(.VEC_W(VEC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (reg_req),
        .set_vec   (req_vector),
        .set_level (req_level),
        .ack_en    (ack_reg),
        .eoi_en    (eoi),
        .irr_found (irr_found),
        .irr_top   (irr_top),
        .isr_found (isr_found),
        .isr_top   (isr_top),
        .top_level (top_level)
    );

    irq_special_flags #(.VEC_W(VEC_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_mode      (req_mode),
        .req_vector    (req_vector),
        .clr_mask      (clr_mask),
        .pending_o     (spec_pending),
        .startup_vec_o (startup_vec),
        .ext_vec_o     (ext_vec)
    );

    // Regular vector must beat the in-service top and the task-priority class.
    assign reg_ok = irr_found &&
                    (!isr_found || (irr_top > isr_top)) &&
                    (irr_top[VEC_W-1:CLS_LO] > task_prio[VEC_W-1:CLS_LO]);

    assign irq_deliverable = (|spec_pending) || reg_ok;
    assign take            = ack && irq_deliverable;

    // Fixed-order winner selection.
    always_comb begin
        if (spec_pending[GK_SMI])           win_kind = GK_SMI;
        else if (spec_pending[GK_NMI])      win_kind = GK_NMI;
        else if (spec_pending[GK_INIT])     win_kind = GK_INIT;
        else if (spec_pending[GK_STARTUP])  win_kind = GK_STARTUP;
        else if (spec_pending[GK_EXTERNAL]) win_kind = GK_EXTERNAL;
        else                                win_kind = GK_REGULAR;
    end

    always_comb begin
        win_vector = '0;
        win_level  = 1'b0;
        unique case (win_kind)
            GK_STARTUP:  win_vector = startup_vec;
            GK_EXTERNAL: win_vector = ext_vec;
            GK_REGULAR: begin
                win_vector = irr_top;
                win_level  = top_level;
            end
            default: win_vector = '0;
        endcase
    end

    always_comb begin
        clr_mask = '0;
        if (take && win_kind != GK_REGULAR) begin
            clr_mask[win_kind] = 1'b1;
        end
    end

    assign ack_reg = take && (win_kind == GK_REGULAR);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = take ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = take ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_kind   <= '0;
            grant_vector <= '0;
            grant_level  <= 1'b0;
        end else if (take) begin
            grant_kind   <= win_kind;
            grant_vector <= win_vector;
            grant_level  <= win_level;
        end
    end

    assign grant_valid = (state_q == ST_PRESENT);

endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk
    import irq_accept_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ack,
    input logic                 irq_deliverable,
    input logic                 grant_valid,
    input logic [2:0]           grant_kind,
    input logic [VEC_W-1:0]     grant_vector,
    input logic [VEC_W-1:0]     task_prio,
    input logic [N_SPECIAL-1:0] spec_pending
);

    // R9
    grant_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_deliverable) |=> grant_valid);

    // R9
    no_grant_without_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_deliverable) |=> !grant_valid);

    // R6
    special_is_deliverable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|spec_pending) |-> irq_deliverable);

    // R8
    smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && spec_pending[GK_SMI]) |=> (grant_kind == GK_SMI));

    // R7
    regular_beats_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_deliverable && spec_pending == '0) |=>
            (grant_vector[VEC_W-1:VEC_W-4] > $past(task_prio[VEC_W-1:VEC_W-4])));

endmodule

bind irq_accept_unit irq_accept_chk #(.VEC_W(VEC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ack             (ack),
    .irq_deliverable (irq_deliverable),
    .grant_valid     (grant_valid),
    .grant_kind      (grant_kind),
    .grant_vector    (grant_vector),
    .task_prio       (task_prio),
    .spec_pending    (spec_pending)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vector = '0;
    logic [2:0] req_mode = '0;
    logic       req_level = 1'b0;
    logic [7:0] task_prio = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_deliverable, grant_valid, grant_level;
    logic [2:0] grant_kind;
    logic [7:0] grant_vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    irq_accept_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level), .task_prio(task_prio),
        .ack(ack), .eoi(eoi), .irq_deliverable(irq_deliverable),
        .grant_valid(grant_valid), .grant_kind(grant_kind),
        .grant_vector(grant_vector), .grant_level(grant_level)
    );

    // Reference state.
    logic [255:0] m_irr = '0, m_tmr = '0, m_isr = '0;
    bit   m_flag [5];
    logic [7:0] m_sipi_vec = '0, m_ext_vec = '0;
    bit   p_gv = 0;
    int   p_kind = 0;
    logic [7:0] p_vec = '0;
    bit   p_lvl = 0;

    function automatic int msb(input logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic logic [2:0] code_of(input int k);
        case (k)
            0: return 3'b010;
            1: return 3'b100;
            2: return 3'b101;
            3: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] vec, input logic [2:0] md,
                        input bit lv, input bit a, input bit e, input logic [7:0] tp);
        int ir, is, wk;
        bit spec, deliv, take, setb;
        @(negedge clk);
        check("R9", {31'd0, grant_valid}, {31'd0, p_gv});
        if (p_gv && grant_valid) begin
            check("R8", {29'd0, grant_kind}, p_kind);
            check((p_kind == 3 || p_kind == 4) ? "R4" : "R9", {24'd0, grant_vector}, {24'd0, p_vec});
            check("R2", {31'd0, grant_level}, {31'd0, p_lvl});
        end
        req_valid = v; req_vector = vec; req_mode = md; req_level = lv;
        ack = a; eoi = e; task_prio = tp;
        #1;
        ir = msb(m_irr);
        is = msb(m_isr);
        spec = 0;
        for (int k = 0; k < 5; k++) spec |= m_flag[k];
        deliv = spec || (ir >= 0 && ir > is && (ir >> 4) > int'(tp[7:4]));
        check(spec ? "R6" : "R7", {31'd0, irq_deliverable}, {31'd0, deliv});
        take = a && deliv;
        wk = 5;
        for (int k = 4; k >= 0; k--) if (m_flag[k]) wk = k;
        p_gv = take;
        p_kind = wk;
        p_vec = (wk == 3) ? m_sipi_vec : (wk == 4) ? m_ext_vec : (wk == 5) ? 8'(ir) : 8'd0;
        p_lvl = (wk == 5 && ir >= 0) ? m_tmr[ir] : 1'b0;
        // Model update.
        for (int k = 0; k < 5; k++) begin
            bit acc;
            acc = v && md == code_of(k) && !m_flag[k];
            if (acc && k == 3) m_sipi_vec = vec;
            if (acc && k == 4) m_ext_vec = vec;
            m_flag[k] = (m_flag[k] && !(take && wk == k)) || acc;
        end
        setb = v && (md == 3'b000 || md == 3'b001) && !m_irr[vec];
        if (take && wk == 5) begin
            m_irr[ir] = 1'b0;
            m_isr[ir] = 1'b1;
        end
        if (e && is >= 0) m_isr[is] = 1'b0;
        if (setb) begin
            m_irr[vec] = 1'b1;
            m_tmr[vec] = lv;
        end
    endtask

    task automatic idle(input logic [7:0] tp);
        step(0, 8'h00, 3'b000, 0, 0, 0, tp);
    endtask

    initial begin
        for (int k = 0; k < 5; k++) m_flag[k] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, irq_deliverable}, 0);
        check("R1", {31'd0, grant_valid}, 0);
        rst_n = 1'b1;
        idle(8'h00);
        check("R1", {31'd0, irq_deliverable}, 0);

        // R5: reserved mode changes nothing
        step(1, 8'hF7, 3'b011, 1, 0, 0, 8'h00);
        idle(8'h00);
        check("R5", {31'd0, irq_deliverable}, 0);

        // R2: level bit kept, duplicate edge request dropped
        step(1, 8'h45, 3'b000, 1, 0, 0, 8'h20);
        step(1, 8'h45, 3'b001, 0, 0, 0, 8'h20);
        step(0, 8'h00, 3'b000, 0, 1, 0, 8'h20);
        idle(8'h20);
        check("R2", {31'd0, grant_level}, 1);
        check("R2", {24'd0, grant_vector}, 32'h45);
        step(0, 8'h00, 3'b000, 0, 0, 1, 8'h20);

        // R3: duplicate special request dropped
        step(1, 8'h00, 3'b010, 0, 0, 0, 8'h00);
        step(1, 8'h00, 3'b010, 0, 0, 0, 8'h00);
        step(0, 8'h00, 3'b000, 0, 1, 0, 8'h00);
        idle(8'h00);
        check("R3", {29'd0, grant_kind}, 0);
        check("R3", {31'd0, irq_deliverable}, 0);

        // R4: stored startup vector not replaced by a dropped duplicate
        step(1, 8'h12, 3'b110, 0, 0, 0, 8'h00);
        step(1, 8'h34, 3'b110, 0, 0, 0, 8'h00);
        step(0, 8'h00, 3'b000, 0, 1, 0, 8'h00);
        idle(8'h00);
        check("R4", {24'd0, grant_vector}, 32'h12);

        // R8: ordering across kinds
        step(1, 8'hF0, 3'b000, 0, 0, 0, 8'h00);
        step(1, 8'h21, 3'b111, 0, 0, 0, 8'h00);
        step(1, 8'h00, 3'b100, 0, 0, 0, 8'h00);
        step(1, 8'h00, 3'b101, 0, 0, 0, 8'h00);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 3'b000, 0, 1, 0, 8'h00);
        idle(8'h00);
        check("R8", {29'd0, grant_kind}, 5);
        step(0, 8'h00, 3'b000, 0, 0, 1, 8'h00);

        // R7 and R10: in-service masking, eoi, class threshold
        step(1, 8'h80, 3'b000, 0, 0, 0, 8'h00);
        step(0, 8'h00, 3'b000, 0, 1, 0, 8'h00);
        step(1, 8'h90, 3'b000, 0, 0, 0, 8'h00);
        step(0, 8'h00, 3'b000, 0, 1, 0, 8'h00);
        step(1, 8'h85, 3'b000, 0, 0, 0, 8'h00);
        idle(8'h00);
        check("R7", {31'd0, irq_deliverable}, 0);
        step(0, 8'h00, 3'b000, 0, 0, 1, 8'h00);
        idle(8'h00);
        check("R10", {31'd0, irq_deliverable}, 1);
        idle(8'h80);
        check("R7", {31'd0, irq_deliverable}, 0);
        step(0, 8'h00, 3'b000, 0, 1, 0, 8'h00);
        step(0, 8'h00, 3'b000, 0, 0, 1, 8'h00);
        step(0, 8'h00, 3'b000, 0, 0, 1, 8'h00);
        step(0, 8'h00, 3'b000, 0, 0, 1, 8'h00);
        idle(8'h00);
        check("R10", {31'd0, irq_deliverable}, 0);

        // Constrained random traffic.
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] tp;
            tp = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 48);
            step(($urandom % 2) == 1, 8'($urandom), 3'($urandom),
                 ($urandom % 2) == 1, ($urandom % 3) == 0, ($urandom % 6) == 0, tp);
        end
        idle(8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule